// File: doc/BRIEF.md
# Dual-Issue Pairing Logic

This block sits in the issue stage of a two-wide front end. Every cycle fetch presents the two instructions that start at the fetch pointer: a left instruction, which may be of any class, and a right instruction that can only be paired with it when the right one is floating point. The block looks at both instructions, their classes, their source operands and the load issued in the cycle before. From these it decides whether nothing, the left instruction alone, or both issue. It also tells fetch how far to move the pointer.

When only the left instruction issues, fetch steps by one instruction. The unissued right instruction then becomes the next left instruction and is judged again on its own. When nothing issues, fetch holds. A load leaves a one-cycle shadow: its result may not be read by the right instruction of its own packet, nor by either instruction of the packet issued next. Integer results other than loads go only to the integer file, and the right slot reads only the floating-point file. Because of that split, a load is the only producer that can collide with a partner inside a packet.

The fetch-side stream has valid/ready semantics:

- Each slot carries its own valid.
- "Ready" is the advance the block returns: `fetch_hold` means zero instructions are taken, `fetch_step2` means two, and otherwise one.
- The execution side applies back-pressure with `ex_ready`. When it is low, nothing issues and fetch holds.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset the load shadow is empty. While `flush` is high nothing issues. A flush also empties the load shadow, so in the cycle after the flush a reader of the last load's destination can issue.
- R2: The left instruction issues exactly when `lft_valid`, `ex_ready` and not `flush` all hold, and none of its enabled sources equals the destination held in the load shadow.
- R3: The right instruction never issues unless the left one issues in the same cycle.
- R4: The right instruction issues only when its class is floating point (code 2) and the left class is not floating point. Class codes are: 0 integer, 1 load, 2 floating point, 3 control.
- R5: The right instruction does not issue if an enabled source equals `lft_dst` while the left instruction is a load (code 1) with `lft_wr` high.
- R6: The right instruction does not issue if an enabled source equals the destination held in the load shadow.
- R7: The load shadow holds a destination only in the cycle directly after a load with `lft_wr` high issued from the left slot. Any other cycle, a stall cycle included, leaves it empty, so a load-use stall lasts exactly one cycle.
- R8: `fetch_hold` is high exactly when the left instruction does not issue. `fetch_step2` is high exactly when the right instruction issues.
- R9: With `ex_ready` low, neither instruction issues and `fetch_hold` is high.
- R10: A source whose read enable is low never blocks issue. A load with `lft_wr` low leaves the shadow empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Suppresses issue and empties the load shadow |
| ex_ready | input | 1 | Execution side can accept a packet this cycle |
| lft_valid | input | 1 | Left instruction present |
| lft_cls | input | 2 | Left class code |
| lft_wr | input | 1 | Left instruction writes a destination |
| lft_dst | input | REG_W | Left destination register |
| lft_rd_en | input | NSRC | Left source read enables |
| lft_src | input | NSRC*REG_W | Left source registers, source k at bits k*REG_W upward |
| rgt_valid | input | 1 | Right instruction present |
| rgt_cls | input | 2 | Right class code |
| rgt_rd_en | input | NSRC | Right source read enables |
| rgt_src | input | NSRC*REG_W | Right source registers, same packing |
| issue_lft | output | 1 | Left instruction issues this cycle |
| issue_rgt | output | 1 | Right instruction issues this cycle |
| fetch_hold | output | 1 | Fetch pointer does not move |
| fetch_step2 | output | 1 | Fetch pointer moves by two instructions |

## Verification
The load-shadow stall of the left slot and the pairing decision for the right slot land in the same cycle. They meet when a load is followed by a packet whose left instruction reads the load's destination and whose right instruction is a valid floating-point instruction that would pair. The sweep sets up every combination: a shadowed or empty previous cycle, all class pairs, both valids, back-pressure, and each dependency of either slot. In each case it compares both issue bits and both fetch outputs with a model built from the requirements. In the colliding case the expected result is that neither instruction issues and fetch holds. Separate directed steps cover a flush arriving while the shadow is full.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_LOAD = 2'd1,
    CLS_FP   = 2'd2,
    CLS_CTRL = 2'd3
  } cls_e;
endpackage

// File: rtl/src_hit.sv
// Flags a match between any enabled source operand and one candidate register.
module src_hit #(
  parameter int REG_W = 6,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0]       rd_en,
  input  logic [NSRC*REG_W-1:0] src,
  input  logic                  cand_valid,
  input  logic [REG_W-1:0]      cand_reg,
  output logic                  hit
);
  logic [NSRC-1:0] per_src;

  for (genvar k = 0; k < NSRC; k++) begin : g_cmp
    assign per_src[k] = rd_en[k] && (src[k*REG_W +: REG_W] == cand_reg);
  end

  assign hit = cand_valid && (|per_src);
endmodule

// File: rtl/load_shadow.sv
// Remembers the destination of a load issued in the previous cycle only.
module load_shadow #(
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ld_issue,
  input  logic [REG_W-1:0] ld_dst,
  output logic             sh_valid,
  output logic [REG_W-1:0] sh_dst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_valid <= 1'b0;
      sh_dst   <= '0;
    end else if (flush) begin
      sh_valid <= 1'b0;
      sh_dst   <= '0;
    end else begin
      sh_valid <= ld_issue;
      sh_dst   <= ld_dst;
    end
  end

  assert_flush_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !sh_valid);

  assert_shadow_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_issue |=> !sh_valid);
endmodule

// File: rtl/pair_rules.sv
// Slot, class and hazard gating for the two issue slots.
module pair_rules
  import pair_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       ex_ready,
  input  logic       lft_valid,
  input  logic [1:0] lft_cls,
  input  logic       lft_shadow_hit,
  input  logic       rgt_valid,
  input  logic [1:0] rgt_cls,
  input  logic       rgt_shadow_hit,
  input  logic       rgt_pair_hit,
  output logic       issue_lft,
  output logic       issue_rgt
);
  logic lft_ok;
  logic class_pair_ok;

  assign lft_ok        = lft_valid && ex_ready && !flush && !lft_shadow_hit;
  assign class_pair_ok = (rgt_cls == CLS_FP) && (lft_cls != CLS_FP);

  always_comb begin
    issue_lft = lft_ok;
    issue_rgt = 1'b0;
    if (lft_ok && rgt_valid && class_pair_ok && !rgt_shadow_hit && !rgt_pair_hit)
      issue_rgt = 1'b1;
  end

  assert_right_needs_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rgt |-> issue_lft);

  assert_right_fp_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rgt |-> (rgt_cls == CLS_FP && lft_cls != CLS_FP));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ready |-> (!issue_lft && !issue_rgt));
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import pair_pkg::*;
#(
  parameter int REG_W = 6,
  parameter int NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  ex_ready,
  input  logic                  lft_valid,
  input  logic [1:0]            lft_cls,
  input  logic                  lft_wr,
  input  logic [REG_W-1:0]      lft_dst,
  input  logic [NSRC-1:0]       lft_rd_en,
  input  logic [NSRC*REG_W-1:0] lft_src,
  input  logic                  rgt_valid,
  input  logic [1:0]            rgt_cls,
  input  logic [NSRC-1:0]       rgt_rd_en,
  input  logic [NSRC*REG_W-1:0] rgt_src,
  output logic                  issue_lft,
  output logic                  issue_rgt,
  output logic                  fetch_hold,
  output logic                  fetch_step2
);
  logic             sh_valid;
  logic [REG_W-1:0] sh_dst;
  logic             lft_is_load;
  logic             ld_issue;
  logic             lft_shadow_hit;
  logic             rgt_shadow_hit;
  logic             rgt_pair_hit;

  assign lft_is_load = (lft_cls == CLS_LOAD) && lft_wr;
  assign ld_issue    = issue_lft && lft_is_load;

  src_hit #(.REG_W(REG_W), .NSRC(NSRC)) i_lft_vs_shadow (
    .rd_en(lft_rd_en), .src(lft_src), .cand_valid(sh_valid), .cand_reg(sh_dst),
    .hit(lft_shadow_hit));

  src_hit #(.REG_W(REG_W), .NSRC(NSRC)) i_rgt_vs_shadow (
    .rd_en(rgt_rd_en), .src(rgt_src), .cand_valid(sh_valid), .cand_reg(sh_dst),
    .hit(rgt_shadow_hit));

  src_hit #(.REG_W(REG_W), .NSRC(NSRC)) i_rgt_vs_lft (
    .rd_en(rgt_rd_en), .src(rgt_src), .cand_valid(lft_is_load), .cand_reg(lft_dst),
    .hit(rgt_pair_hit));

  load_shadow #(.REG_W(REG_W)) i_shadow (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ld_issue(ld_issue), .ld_dst(lft_dst),
    .sh_valid(sh_valid), .sh_dst(sh_dst));

  pair_rules i_rules (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ex_ready(ex_ready),
    .lft_valid(lft_valid), .lft_cls(lft_cls), .lft_shadow_hit(lft_shadow_hit),
    .rgt_valid(rgt_valid), .rgt_cls(rgt_cls), .rgt_shadow_hit(rgt_shadow_hit),
    .rgt_pair_hit(rgt_pair_hit), .issue_lft(issue_lft), .issue_rgt(issue_rgt));

  assign fetch_hold  = !issue_lft;
  assign fetch_step2 = issue_rgt;

  // One-cycle qualifier so $past never reaches back into reset.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_flush_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !issue_lft);

  assert_load_use_stall_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(issue_lft && lft_cls == CLS_LOAD && lft_wr && !flush) && lft_rd_en[0] &&
     lft_src[REG_W-1:0] == $past(lft_dst)) |-> !issue_lft);

  assert_same_packet_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_cls == CLS_LOAD && lft_wr && rgt_rd_en[0] &&
     rgt_src[REG_W-1:0] == lft_dst) |-> !issue_rgt);

  assert_step_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_step2 |-> !fetch_hold);
endmodule

// File: tb/test_dual_issue_pair.sv
`timescale 1ns/1ps
module test_dual_issue_pair;
  localparam int REG_W = 6;
  localparam int NSRC  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, flush, ex_ready;
  logic lft_valid, lft_wr, rgt_valid;
  logic [1:0] lft_cls, rgt_cls;
  logic [REG_W-1:0] lft_dst;
  logic [NSRC-1:0] lft_rd_en, rgt_rd_en;
  logic [NSRC*REG_W-1:0] lft_src, rgt_src;
  logic issue_lft, issue_rgt, fetch_hold, fetch_step2;

  int checks = 0;
  int errors = 0;

  dual_issue_pair #(.REG_W(REG_W), .NSRC(NSRC)) i_dual_issue_pair (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ex_ready(ex_ready),
    .lft_valid(lft_valid), .lft_cls(lft_cls), .lft_wr(lft_wr), .lft_dst(lft_dst),
    .lft_rd_en(lft_rd_en), .lft_src(lft_src),
    .rgt_valid(rgt_valid), .rgt_cls(rgt_cls), .rgt_rd_en(rgt_rd_en), .rgt_src(rgt_src),
    .issue_lft(issue_lft), .issue_rgt(issue_rgt),
    .fetch_hold(fetch_hold), .fetch_step2(fetch_step2));

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // Drive one packet at the falling edge; outputs are sampled 1 ns later.
  task automatic drive(input logic fl, input logic rdy,
                       input logic lv, input logic [1:0] lc, input logic lw,
                       input logic [REG_W-1:0] ld, input logic [NSRC-1:0] lre,
                       input logic [REG_W-1:0] ls0, input logic [REG_W-1:0] ls1,
                       input logic rv, input logic [1:0] rc, input logic [NSRC-1:0] rre,
                       input logic [REG_W-1:0] rs0, input logic [REG_W-1:0] rs1);
    @(negedge clk);
    flush = fl; ex_ready = rdy;
    lft_valid = lv; lft_cls = lc; lft_wr = lw; lft_dst = ld; lft_rd_en = lre;
    lft_src = {ls1, ls0};
    rgt_valid = rv; rgt_cls = rc; rgt_rd_en = rre; rgt_src = {rs1, rs0};
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 6'd0, 2'b00, 6'd0, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0;
    flush = 1'b0; ex_ready = 1'b0;
    lft_valid = 1'b0; lft_cls = 2'd0; lft_wr = 1'b0; lft_dst = '0; lft_rd_en = '0; lft_src = '0;
    rgt_valid = 1'b0; rgt_cls = 2'd0; rgt_rd_en = '0; rgt_src = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty shadow after reset, reader of register 0 issues with its FP partner.
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd1, 2'b11, 6'd0, 6'd0,
          1'b1, 2'd2, 2'b11, 6'd0, 6'd0);
    check(issue_lft, 1'b1, "R1", "reset shadow empty, left");
    check(issue_rgt, 1'b1, "R1", "reset shadow empty, right");

    // R1: load, then a flush with a valid packet, then a dependent reader.
    drive(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 6'd7, 2'b00, 6'd0, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b1, "R1", "load before flush");
    drive(1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b00, 6'd0, 6'd0,
          1'b1, 2'd2, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b0, "R1", "flush blocks left");
    check(issue_rgt, 1'b0, "R1", "flush blocks right");
    check(fetch_hold, 1'b1, "R1", "flush holds fetch");
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b01, 6'd7, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b1, "R1", "shadow emptied by flush");

    // R10: a disabled source that matches never blocks; a non-writing load is not remembered.
    drive(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 6'd8, 2'b00, 6'd0, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b10, 6'd8, 6'd3,
          1'b1, 2'd2, 2'b10, 6'd8, 6'd3);
    check(issue_lft, 1'b1, "R10", "disabled left source");
    check(issue_rgt, 1'b1, "R10", "disabled right source");
    drive(1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 6'd9, 2'b00, 6'd0, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b01, 6'd9, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b1, "R10", "load without write leaves shadow empty");

    // R7: the load-use stall lasts one cycle, then the same reader issues.
    drive(1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 6'd11, 2'b00, 6'd0, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b01, 6'd11, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b0, "R7", "reader stalled in shadow");
    drive(1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 6'd2, 2'b01, 6'd11, 6'd0,
          1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
    check(issue_lft, 1'b1, "R7", "reader issues after one stall");

    // Sweep: setup cycle (load or integer to register 5), then a test packet.
    for (int pl = 0; pl < 2; pl++)
    for (int lc = 0; lc < 4; lc++)
    for (int rc = 0; rc < 4; rc++)
    for (int lv = 0; lv < 2; lv++)
    for (int rv = 0; rv < 2; rv++)
    for (int rdy = 0; rdy < 2; rdy++)
    for (int ldp = 0; ldp < 2; ldp++)
    for (int rdp = 0; rdp < 2; rdp++)
    for (int rdl = 0; rdl < 2; rdl++) begin
      logic sh, el, er;
      idle();
      drive(1'b0, 1'b1, 1'b1, (pl != 0) ? 2'd1 : 2'd0, 1'b1, 6'd5, 2'b00, 6'd0, 6'd0,
            1'b0, 2'd0, 2'b00, 6'd0, 6'd0);
      sh = (pl != 0);
      drive(1'b0, rdy[0], lv[0], lc[1:0], 1'b1, 6'd9, 2'b11,
            (ldp != 0) ? 6'd5 : 6'd3, 6'd4,
            rv[0], rc[1:0], 2'b11,
            (rdp != 0) ? 6'd5 : 6'd12, (rdl != 0) ? 6'd9 : 6'd13);
      el = lv[0] && rdy[0] && !(sh && ldp != 0);
      er = el && rv[0] && (rc == 2) && (lc != 2) && !(sh && rdp != 0) &&
           !(lc == 1 && rdl != 0);
      check(issue_lft, el, "R2", "sweep left issue");
      check(issue_rgt, er, "R3", "sweep right issue (R4 R5 R6 R9)");
      check(fetch_hold, !el, "R8", "sweep fetch hold");
      check(fetch_step2, er, "R8", "sweep fetch step");
      if (rdy == 0) check(issue_lft | issue_rgt, 1'b0, "R9", "back-pressure");
      if (rc == 2 && lc != 2 && lv != 0 && rv != 0 && rdy != 0 && ldp == 0 && rdp == 0) begin
        if (lc == 1 && rdl != 0) check(issue_rgt, 1'b0, "R5", "same-packet load use");
        if (sh && rdl == 0) check(issue_rgt, 1'b1, "R6", "shadow without right hit pairs");
      end
      if (sh && rdp != 0 && ldp == 0 && lv != 0 && rdy != 0)
        check(issue_rgt, 1'b0, "R6", "right reads shadowed load");
      if (rc != 2 && lv != 0 && rdy != 0 && !(sh && ldp != 0))
        check(issue_rgt, 1'b0, "R4", "non-FP right stays");
    end

    idle();
    finish_up();
  end
endmodule